// File: doc/BRIEF.md
# Dual Packet-Number Queue Status Port

This block holds two small queues of packet numbers and presents the head of each, with an empty flag, through one read-only 16-bit status word. One queue collects the numbers of received packets; the other collects the numbers of transmit packets that have finished. The receive side and the transmit side push numbers into their queues through push strobes. The host reads the status word to learn which packet each service routine handles next.

Reading the word never changes a queue. The head of the receive queue leaves only on a receive-remove strobe. The head of the completion queue leaves only on a transmit-interrupt acknowledge strobe. Host writes aimed at the word are accepted on the bus and thrown away. Each queue keeps a sticky overflow flag that is set when a push arrives while the queue is full and is dropped.

Top module: `pktq_status_port`

## Requirements
- R1: After reset the status word reads 16'h8080 (both empty flags set, both number fields zero) and both overflow flags read 0.
- R2: Bit 15 of the status word is 1 exactly when the receive queue is empty. Bits 13:8 hold the number at the receive head. Bit 14 reads 0. The word is registered, so it shows the queue state one clock after that state changes.
- R3: Bit 7 of the status word is 1 exactly when the completion queue is empty. Bits 5:0 hold the number at the completion head. Bit 6 reads 0.
- R4: Reading is passive. The head of the receive queue changes only on `rx_remove` or on a push into an empty queue. The head of the completion queue changes only on `tx_ack` or on a push into an empty queue.
- R5: Each queue hands out its numbers in the order they were pushed.
- R6: A host write (`host_wr` with any `host_wdata`) has no effect on the status word or on either overflow flag.
- R7: Each queue holds 4 entries. A push into a full queue with no pop in the same cycle is dropped, and it sets that queue's overflow flag, which stays set until reset.
- R8: A pop strobe on an empty queue is ignored. A push in the same cycle is still accepted.
- R9: A push and a pop in the same cycle on a non-empty queue (full included) remove the head and append the new number, so the occupancy stays the same.
- R10: While a queue is empty, its number field reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_push | input | 1 | Append `rx_push_num` to the receive queue |
| rx_push_num | input | PNUM_W | Received packet number |
| rx_remove | input | 1 | Receive-remove command: pop the receive head |
| tx_push | input | 1 | Append `tx_push_num` to the completion queue |
| tx_push_num | input | PNUM_W | Finished transmit packet number |
| tx_ack | input | 1 | Transmit-interrupt acknowledge: pop the completion head |
| host_wr | input | 1 | Host write strobe aimed at the status word (ignored) |
| host_wdata | input | 16 | Host write data (ignored) |
| stat_word | output | 16 | Registered status word |
| rx_ovf | output | 1 | Sticky receive-queue overflow |
| tx_ovf | output | 1 | Sticky completion-queue overflow |

## Verification
The bench builds the block with its defaults: 6-bit packet numbers and 4-entry queues. With queues this shallow, full, overflow, push-while-full-with-pop and pop-on-empty are reached within a few cycles of random strobes, so every edge of the occupancy range is visited many times. The 6-bit width lets random numbers cover every field value, zero included, which separates a genuine head of 0 from the zero shown for an empty queue only through the flag bit. A behavioural queue model predicts the status word and overflow flags on every clock, and directed sequences pin down ordering, write immunity and the empty corners.

// File: rtl/pktq_pkg.sv
package pktq_pkg;
  localparam int STAT_W   = 16;
  localparam int HALF_W   = 8;
  localparam int FIELD_W  = 7;

  function automatic logic [HALF_W-1:0] pack_half(input logic empty,
                                                  input logic [FIELD_W-1:0] num);
    logic [HALF_W-1:0] b;
    b = {1'b0, num};
    b[HALF_W-1] = empty;
    b[HALF_W-2] = 1'b0;
    return b;
  endfunction
endpackage

// File: rtl/pktq_fifo.sv
module pktq_fifo #(
  parameter int W     = 6,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_num,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_pop, do_push, is_full;

  assign empty   = (count == '0);
  assign is_full = (count == CW'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!is_full || do_pop);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_num;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push && !do_push) ovf <= 1'b1;
    end
  end

  assign head = empty ? '0 : mem[rd_ptr];

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH)); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf); // R7
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (is_full && push && !pop) |=> (ovf && count == CW'(DEPTH))); // R7
  AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push) |=> (count == '0)); // R8
  AST_PUSHPOP_KEEP: assert property (@(posedge clk) disable iff (rst)
    (!empty && push && pop) |=> $stable(count)); // R9
endmodule

// File: rtl/pktq_word_pack.sv
module pktq_word_pack
  import pktq_pkg::*;
#(
  parameter int W = 6
) (
  input  logic              rx_empty,
  input  logic [W-1:0]      rx_head,
  input  logic              tx_empty,
  input  logic [W-1:0]      tx_head,
  output logic [STAT_W-1:0] word
);
  always_comb begin
    word = {pack_half(rx_empty, FIELD_W'(rx_head)),
            pack_half(tx_empty, FIELD_W'(tx_head))};
  end
endmodule

// File: rtl/pktq_status_port.sv
module pktq_status_port
  import pktq_pkg::*;
#(
  parameter int PNUM_W = 6,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_push,
  input  logic [PNUM_W-1:0] rx_push_num,
  input  logic              rx_remove,
  input  logic              tx_push,
  input  logic [PNUM_W-1:0] tx_push_num,
  input  logic              tx_ack,
  input  logic              host_wr,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       stat_word,
  output logic              rx_ovf,
  output logic              tx_ovf
);
  logic [PNUM_W-1:0] rx_head, tx_head;
  logic              rx_empty, tx_empty;
  logic [STAT_W-1:0] word_next;
  logic              unused_host;

  // the status word is read-only: host writes are dropped here
  assign unused_host = ^{host_wr, host_wdata};

  pktq_fifo #(.W(PNUM_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .push(rx_push), .push_num(rx_push_num),
    .pop(rx_remove), .head(rx_head), .empty(rx_empty), .ovf(rx_ovf)
  );

  pktq_fifo #(.W(PNUM_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .push(tx_push), .push_num(tx_push_num),
    .pop(tx_ack), .head(tx_head), .empty(tx_empty), .ovf(tx_ovf)
  );

  pktq_word_pack #(.W(PNUM_W)) u_pack (
    .rx_empty(rx_empty), .rx_head(rx_head),
    .tx_empty(tx_empty), .tx_head(tx_head),
    .word(word_next)
  );

  always_ff @(posedge clk) begin
    if (rst) stat_word <= 16'h8080;
    else     stat_word <= word_next;
  end

  AST_RX_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
    stat_word[15] |-> (stat_word[14:8] == '0)); // R10
  AST_TX_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
    stat_word[7] |-> (stat_word[6:0] == '0)); // R10
  AST_RX_FLAG_TRACK: assert property (@(posedge clk) disable iff (rst)
    rx_empty |=> stat_word[15]); // R2
  AST_TX_FLAG_TRACK: assert property (@(posedge clk) disable iff (rst)
    tx_empty |=> stat_word[7]); // R3
  AST_SPARE_BITS: assert property (@(posedge clk) disable iff (rst)
    (!stat_word[14] && !stat_word[6])); // R2
endmodule

// File: tb/sim_pktq_status_port.sv
`timescale 1ns/1ps
module sim_pktq_status_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_push = 0, rx_remove = 0, tx_push = 0, tx_ack = 0, host_wr = 0;
  logic [5:0]  rx_push_num = 0, tx_push_num = 0;
  logic [15:0] host_wdata = 0;
  logic [15:0] stat_word;
  logic        rx_ovf, tx_ovf;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  pktq_status_port u0 (
    .clk(clk), .rst(rst),
    .rx_push(rx_push), .rx_push_num(rx_push_num), .rx_remove(rx_remove),
    .tx_push(tx_push), .tx_push_num(tx_push_num), .tx_ack(tx_ack),
    .host_wr(host_wr), .host_wdata(host_wdata),
    .stat_word(stat_word), .rx_ovf(rx_ovf), .tx_ovf(tx_ovf)
  );

  // behavioural reference
  int          rxq[$];
  int          txq[$];
  logic [15:0] exp_word = 16'h8080;
  logic        exp_rxo = 0, exp_txo = 0;

  function automatic logic [7:0] half(input int q[$]);
    if (q.size() == 0) return 8'h80;
    return {2'b00, 6'(q[0])};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      rxq.delete(); txq.delete();
      exp_word = 16'h8080; exp_rxo = 0; exp_txo = 0;
    end else begin
      bit popped;
      exp_word = {half(rxq), half(txq)};
      popped = 0;
      if (rx_remove && rxq.size() > 0) begin void'(rxq.pop_front()); popped = 1; end
      if (rx_push) begin
        if (rxq.size() < 4) rxq.push_back(int'(rx_push_num));
        else exp_rxo = 1;
      end
      popped = 0;
      if (tx_ack && txq.size() > 0) begin void'(txq.pop_front()); popped = 1; end
      if (tx_push) begin
        if (txq.size() < 4) txq.push_back(int'(tx_push_num));
        else exp_txo = 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R2", {8'h00, stat_word[15:8]}, {8'h00, exp_word[15:8]});
      chk("R3", {8'h00, stat_word[7:0]}, {8'h00, exp_word[7:0]});
      chk("R7", {14'h0, rx_ovf, tx_ovf}, {14'h0, exp_rxo, exp_txo});
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic rp, input logic [5:0] rn, input logic rr,
                       input logic tp, input logic [5:0] tn, input logic ta);
    rx_push = rp; rx_push_num = rn; rx_remove = rr;
    tx_push = tp; tx_push_num = tn; tx_ack = ta;
    @(negedge clk);
    rx_push = 0; rx_remove = 0; tx_push = 0; tx_ack = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1", stat_word, 16'h8080);
    chk("R1", {14'h0, rx_ovf, tx_ovf}, 16'h0);

    pulse(1, 6'd5, 0, 0, 0, 0); idle(1);
    chk("R2", stat_word, 16'h0580);
    pulse(0, 0, 0, 1, 6'h2A, 0); idle(1);
    chk("R3", stat_word, 16'h052A);

    idle(5);
    chk("R4", stat_word, 16'h052A);
    host_wr = 1; host_wdata = 16'hFFFF; idle(1);
    host_wdata = 16'h0000; idle(1); host_wr = 0; idle(1);
    chk("R6", stat_word, 16'h052A);
    chk("R6", {14'h0, rx_ovf, tx_ovf}, 16'h0);

    pulse(1, 6'd7, 0, 0, 0, 0);
    pulse(1, 6'd9, 0, 0, 0, 0);
    pulse(1, 6'd11, 0, 0, 0, 0);
    pulse(1, 6'd13, 0, 0, 0, 0); idle(1);
    chk("R7", {15'h0, rx_ovf}, 16'h1);
    chk("R7", stat_word, 16'h052A);
    pulse(0, 0, 1, 0, 0, 0); idle(1);
    chk("R5", stat_word, 16'h072A);
    chk("R7", {15'h0, rx_ovf}, 16'h1);

    pulse(1, 6'd4, 1, 0, 0, 0); idle(1);
    chk("R9", stat_word, 16'h092A);
    pulse(1, 6'd20, 1, 0, 0, 0); idle(1);
    chk("R9", stat_word, 16'h0B2A);
    chk("R9", {15'h0, rx_ovf}, 16'h1);
    pulse(0, 0, 1, 0, 0, 0); idle(1);
    chk("R5", stat_word, 16'h042A);
    pulse(0, 0, 1, 0, 0, 0); idle(1);
    chk("R5", stat_word, 16'h142A);
    pulse(0, 0, 1, 0, 0, 0); idle(1);
    chk("R10", stat_word, 16'h802A);

    pulse(0, 0, 1, 0, 0, 0); pulse(0, 0, 1, 0, 0, 0); idle(1);
    chk("R8", stat_word, 16'h802A);
    pulse(1, 6'd3, 1, 0, 0, 0); idle(1);
    chk("R8", stat_word, 16'h032A);
    pulse(0, 0, 0, 0, 0, 1); pulse(0, 0, 0, 0, 0, 1); idle(1);
    chk("R10", stat_word, 16'h0380);
    chk("R7", {15'h0, tx_ovf}, 16'h0);

    for (int i = 0; i < 3000; i++) begin
      rx_push     = ($urandom_range(0, 2) == 0);
      rx_push_num = 6'($urandom_range(0, 63));
      rx_remove   = ($urandom_range(0, 3) == 0);
      tx_push     = ($urandom_range(0, 2) == 0);
      tx_push_num = 6'($urandom_range(0, 63));
      tx_ack      = ($urandom_range(0, 3) == 0);
      host_wr     = ($urandom_range(0, 4) == 0);
      host_wdata  = 16'($urandom);
      @(negedge clk);
    end
    rx_push = 0; rx_remove = 0; tx_push = 0; tx_ack = 0; host_wr = 0;
    idle(3);

    rst = 1; idle(2); rst = 0; idle(1);
    chk("R1", stat_word, 16'h8080);
    chk("R1", {14'h0, rx_ovf, tx_ovf}, 16'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule